// File: doc/BRIEF.md
# Processor Sleep Mode Controller

This block decides when a small microcontroller core goes to sleep and which clock and power domains stay alive. It has three ways into sleep: a wait-for-interrupt pulse, which sleeps without any condition; a wait-for-event pulse, which sleeps only if no event is waiting in a one-bit event latch; and an exception return to thread mode while the sleep-on-exit control bit is set. A deep-select bit, sampled when sleep begins, picks the depth. Light sleep gates only the core clock. Deep sleep also gates the system clock and turns off the PLL and memory power.

The wake sources depend on how sleep began. A pending interrupt always wakes the core. The external event input also wakes it after a wait-for-event entry. The wake-up controller line is an optional path that works in deep sleep only. Waking from deep sleep is a staged sequence: memory and PLL power come on first, then the system clock, and the core clock comes on last. Each stage holds for a parameterised number of cycles. An external event that arrives while the core runs is stored in the latch, so a later wait-for-event returns at once and clears it.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the mode output is 0 (run) and all four enables (core clock, system clock, PLL power, memory power) are 1.
- R2: A wait-for-interrupt pulse in run mode enters sleep on the next clock edge, whatever the event latch holds. When wait-for-interrupt and wait-for-event arrive together, wait-for-interrupt wins and the event latch is left unchanged.
- R3: A wait-for-event pulse in run mode sleeps if the event latch is clear and no external event arrives in the same cycle. Otherwise the core stays in run mode and the latch is cleared.
- R4: An exception-return pulse enters sleep only when the sleep-on-exit bit is 1. With the bit at 0 it has no effect.
- R5: Light sleep is mode code 1. In this mode only the core clock enable is 0.
- R6: Deep sleep is mode code 2, with all four enables at 0. The deep-select bit is sampled on the entry edge, and later changes to it have no effect.
- R7: After a wait-for-interrupt or sleep-on-exit entry, only a pending interrupt wakes the core. An external event seen during that sleep neither wakes the core nor sets the event latch.
- R8: After a wait-for-event entry, either a pending interrupt or the external event input wakes the core.
- R9: The wake-up controller line wakes the core from deep sleep. It is ignored in light sleep.
- R10: A wake from light sleep returns to run mode on the next edge. A wake from deep sleep passes through two stages before run mode. The first is mode 3, with memory and PLL power on. The second is mode 4, which adds the system clock. Each stage lasts STEP_GAP cycles, and the core clock comes on last.
- R11: An external event seen in run mode sets the event latch, so the next wait-for-event does not sleep.
- R12: Sleep requests that arrive during the deep-wake stages are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt pulse |
| wfe_i | input | 1 | Wait-for-event pulse |
| exc_ret_i | input | 1 | Exception return to thread mode pulse |
| sleep_on_exit_i | input | 1 | Sleep-on-exit control bit |
| deep_sel_i | input | 1 | 1 selects deep sleep, 0 selects light sleep |
| irq_pend_i | input | 1 | A pending enabled interrupt exists |
| ext_evt_i | input | 1 | External event input |
| wic_wake_i | input | 1 | Wake-up controller request |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| pll_pwr_en_o | output | 1 | PLL power enable |
| mem_pwr_en_o | output | 1 | Memory power enable |
| mode_o | output | 3 | 0 run, 1 light, 2 deep, 3 wake-power, 4 wake-clock |

## Verification
The assertions assume that the request inputs are single-cycle pulses. They also assume that the level inputs (interrupt pending, wake-up controller, control bits) change only between clock edges. The stimulus meets both assumptions: it drives every input on the falling edge and clears each pulse after exactly one rising edge. Interrupt and wake-up requests are held for one cycle and then dropped. This avoids overlap with the next entry and keeps each expected mode unambiguous.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
   typedef enum logic [2:0] {
      MODE_RUN   = 3'd0,
      MODE_LIGHT = 3'd1,
      MODE_DEEP  = 3'd2,
      MODE_WPWR  = 3'd3,
      MODE_WCLK  = 3'd4
   } pwr_mode_e;

   typedef struct packed {
      logic core;
      logic sys;
      logic pll;
      logic mem;
   } pwr_en_t;
endpackage

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ext_evt_i,
   input  logic consume_i,
   output logic evt_seen_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_q <= 1'b0;
      else if (consume_i)         flag_q <= 1'b0;
      else if (run_i && ext_evt_i) flag_q <= 1'b1;
   end

   assign evt_seen_o = flag_q | ext_evt_i;

   // R11: an event while running is remembered
   p_evt_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && ext_evt_i && !consume_i) |=> flag_q);
   // R3: a consumed event leaves the latch empty
   p_evt_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      consume_i |=> !flag_q);
endmodule

// File: rtl/pwr_wake_src.sv
module pwr_wake_src #(
   parameter bit HAS_WIC = 1'b1
) (
   input  logic sleep_wfe_i,
   input  logic in_deep_i,
   input  logic irq_pend_i,
   input  logic ext_evt_i,
   input  logic wic_wake_i,
   output logic wake_o
);
   logic wic_ok;

   generate
      if (HAS_WIC) begin : g_wic
         assign wic_ok = wic_wake_i & in_deep_i;
      end else begin : g_no_wic
         logic unused_wic;
         assign unused_wic = wic_wake_i ^ in_deep_i;
         assign wic_ok = 1'b0;
      end
   endgenerate

   assign wake_o = irq_pend_i | (sleep_wfe_i & ext_evt_i) | wic_ok;
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
   import pwr_sleep_pkg::*;
#(
   parameter int STEP_GAP = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wfi_i,
   input  logic      wfe_i,
   input  logic      exc_ret_i,
   input  logic      sleep_on_exit_i,
   input  logic      deep_sel_i,
   input  logic      evt_seen_i,
   input  logic      wake_i,
   output logic      consume_o,
   output logic      sleep_wfe_o,
   output pwr_mode_e mode_o,
   output pwr_en_t   en_o
);
   localparam int CW = (STEP_GAP < 2) ? 1 : $clog2(STEP_GAP);
   localparam logic [CW-1:0] LAST = CW'(STEP_GAP - 1);

   generate
      if (STEP_GAP < 1) begin : g_bad_gap
         $error("STEP_GAP must be at least 1");
      end
   endgenerate

   pwr_mode_e     state_q, state_d;
   logic          kind_wfe_q, kind_wfe_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          enter, enter_wfe;

   assign enter_wfe = !wfi_i && wfe_i && !evt_seen_i;
   assign enter     = (state_q == MODE_RUN) &&
                      (wfi_i || enter_wfe || (exc_ret_i && sleep_on_exit_i));
   assign consume_o = (state_q == MODE_RUN) && !wfi_i && wfe_i && evt_seen_i;

   always_comb begin
      state_d    = state_q;
      kind_wfe_d = kind_wfe_q;
      cnt_d      = cnt_q;
      unique case (state_q)
         MODE_RUN: begin
            if (enter) begin
               state_d    = deep_sel_i ? MODE_DEEP : MODE_LIGHT;
               kind_wfe_d = enter_wfe;
            end
         end
         MODE_LIGHT: if (wake_i) state_d = MODE_RUN;
         MODE_DEEP: begin
            if (wake_i) begin
               state_d = MODE_WPWR;
               cnt_d   = '0;
            end
         end
         MODE_WPWR: begin
            if (cnt_q == LAST) begin
               state_d = MODE_WCLK;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         MODE_WCLK: begin
            if (cnt_q == LAST) begin
               state_d = MODE_RUN;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= MODE_RUN;
         kind_wfe_q <= 1'b0;
         cnt_q      <= '0;
      end else begin
         state_q    <= state_d;
         kind_wfe_q <= kind_wfe_d;
         cnt_q      <= cnt_d;
      end
   end

   always_comb begin
      unique case (state_q)
         MODE_RUN:   en_o = '{core: 1'b1, sys: 1'b1, pll: 1'b1, mem: 1'b1};
         MODE_LIGHT: en_o = '{core: 1'b0, sys: 1'b1, pll: 1'b1, mem: 1'b1};
         MODE_WPWR:  en_o = '{core: 1'b0, sys: 1'b0, pll: 1'b1, mem: 1'b1};
         MODE_WCLK:  en_o = '{core: 1'b0, sys: 1'b1, pll: 1'b1, mem: 1'b1};
         default:    en_o = '{core: 1'b0, sys: 1'b0, pll: 1'b0, mem: 1'b0};
      endcase
   end

   assign mode_o      = state_q;
   assign sleep_wfe_o = kind_wfe_q;

   // R2: wait-for-interrupt in run always leaves run
   p_wfi_sleeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_RUN && wfi_i) |=> (state_q == MODE_LIGHT || state_q == MODE_DEEP));
   // R10: system clock returns only after memory and PLL power are up
   p_sys_after_pwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o.sys) && $past(state_q) != MODE_RUN |-> $past(en_o.mem && en_o.pll));
   // R10: core clock is the last domain to return
   p_core_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o.core) |-> $past(en_o.sys && en_o.mem && en_o.pll));
   // R12: no sleep entry from the wake stages
   p_stage_no_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_WPWR) |=> (state_q == MODE_WPWR || state_q == MODE_WCLK));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
   import pwr_sleep_pkg::*;
#(
   parameter int STEP_GAP = 2,
   parameter bit HAS_WIC  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wfi_i,
   input  logic       wfe_i,
   input  logic       exc_ret_i,
   input  logic       sleep_on_exit_i,
   input  logic       deep_sel_i,
   input  logic       irq_pend_i,
   input  logic       ext_evt_i,
   input  logic       wic_wake_i,
   output logic       core_clk_en_o,
   output logic       sys_clk_en_o,
   output logic       pll_pwr_en_o,
   output logic       mem_pwr_en_o,
   output logic [2:0] mode_o
);
   pwr_mode_e mode;
   pwr_en_t   en;
   logic      evt_seen, consume, sleep_wfe, wake;

   pwr_evt_latch u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (mode == MODE_RUN),
      .ext_evt_i  (ext_evt_i),
      .consume_i  (consume),
      .evt_seen_o (evt_seen)
   );

   pwr_wake_src #(.HAS_WIC(HAS_WIC)) u_wake (
      .sleep_wfe_i (sleep_wfe),
      .in_deep_i   (mode == MODE_DEEP),
      .irq_pend_i  (irq_pend_i),
      .ext_evt_i   (ext_evt_i),
      .wic_wake_i  (wic_wake_i),
      .wake_o      (wake)
   );

   pwr_sleep_fsm #(.STEP_GAP(STEP_GAP)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .wfi_i           (wfi_i),
      .wfe_i           (wfe_i),
      .exc_ret_i       (exc_ret_i),
      .sleep_on_exit_i (sleep_on_exit_i),
      .deep_sel_i      (deep_sel_i),
      .evt_seen_i      (evt_seen),
      .wake_i          (wake),
      .consume_o       (consume),
      .sleep_wfe_o     (sleep_wfe),
      .mode_o          (mode),
      .en_o            (en)
   );

   assign core_clk_en_o = en.core;
   assign sys_clk_en_o  = en.sys;
   assign pll_pwr_en_o  = en.pll;
   assign mem_pwr_en_o  = en.mem;
   assign mode_o        = mode;

   // R7: light sleep entered by wait-for-interrupt holds without an interrupt
   p_light_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LIGHT && !sleep_wfe && !irq_pend_i) |=> (mode == MODE_LIGHT));
   // R9: the wake-up controller alone never ends light sleep
   p_wic_light_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LIGHT && !irq_pend_i && !ext_evt_i) |=> (mode == MODE_LIGHT));
   // R4: exception return without sleep-on-exit keeps running
   p_exit_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RUN && exc_ret_i && !sleep_on_exit_i && !wfi_i && !wfe_i) |=> (mode == MODE_RUN));
endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb;
   localparam int GAP = 2;
   localparam logic [2:0] RUN = 3'd0, LIT = 3'd1, DEP = 3'd2, WPW = 3'd3, WCK = 3'd4;

   typedef struct {
      logic [2:0] mode;
      string      tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wfi = 0, wfe = 0, exr = 0, soe = 0, deep = 0, irq = 0, evt = 0, wic = 0;
   logic core_en, sys_en, pll_en, mem_en;
   logic [2:0] mode;
   int checks = 0, failures = 0;
   bit done = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   pwr_sleep_ctrl #(.STEP_GAP(GAP), .HAS_WIC(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .exc_ret_i(exr),
      .sleep_on_exit_i(soe), .deep_sel_i(deep), .irq_pend_i(irq),
      .ext_evt_i(evt), .wic_wake_i(wic), .core_clk_en_o(core_en),
      .sys_clk_en_o(sys_en), .pll_pwr_en_o(pll_en), .mem_pwr_en_o(mem_en),
      .mode_o(mode));

   // enables {core,sys,pll,mem} each mode must show
   function automatic logic [3:0] en_of(input logic [2:0] m);
      case (m)
         RUN:     return 4'b1111;
         LIT:     return 4'b0111;
         WPW:     return 4'b0011;
         WCK:     return 4'b0111;
         default: return 4'b0000;
      endcase
   endfunction

   // driver: queue the expectation for the next edge, then clear pulses
   task automatic cyc(input logic [2:0] m, input string tag);
      exp_t e;
      e.mode = m;
      e.tag  = tag;
      sb_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      wfi = 0; wfe = 0; exr = 0; evt = 0;
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (mode !== e.mode || {core_en, sys_en, pll_en, mem_en} !== en_of(e.mode)) begin
            failures++;
            $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
                     e.tag, mode, {core_en, sys_en, pll_en, mem_en}, e.mode, en_of(e.mode));
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(RUN, "R1 reset state");
      // light sleep by wfi, event ignored, interrupt wakes
      wfi = 1;            cyc(LIT, "R2 R5 wfi enters light");
                          cyc(LIT, "R5 light holds");
      evt = 1;            cyc(LIT, "R7 event ignored in wfi sleep");
      irq = 1;            cyc(RUN, "R7 irq wakes"); irq = 0;
      // event during wfi sleep was not latched
      wfe = 1;            cyc(LIT, "R7 R3 wfe sleeps with empty latch");
      evt = 1;            cyc(RUN, "R8 event wakes wfe sleep");
      // event while running is latched
      evt = 1;            cyc(RUN, "R11 event while running");
      wfe = 1;            cyc(RUN, "R11 wfe returns at once");
      wfe = 1;            cyc(LIT, "R3 latch cleared, wfe sleeps");
      irq = 1;            cyc(RUN, "R8 irq wakes wfe sleep"); irq = 0;
      // simultaneous event and wfe
      wfe = 1; evt = 1;   cyc(RUN, "R3 wfe with same-cycle event");
      wfe = 1;            cyc(LIT, "R3 same-cycle event consumed");
      irq = 1;            cyc(RUN, "R8 irq wake"); irq = 0;
      // sleep on exit
      exr = 1;            cyc(RUN, "R4 exit without control bit");
      soe = 1; exr = 1;   cyc(LIT, "R4 exit with control bit");
      irq = 1;            cyc(RUN, "R4 irq wake"); irq = 0; soe = 0;
      // deep sleep and staged wake
      deep = 1; wfi = 1;  cyc(DEP, "R6 wfi enters deep");
      deep = 0;           cyc(DEP, "R6 select sampled at entry");
      irq = 1;            cyc(WPW, "R10 power stage"); irq = 0;
      for (int i = 1; i < GAP; i++) cyc(WPW, "R10 power stage hold");
      for (int i = 0; i < GAP; i++) cyc(WCK, "R10 clock stage");
                          cyc(RUN, "R10 core clock last");
      // wake-up controller
      wfi = 1;            cyc(LIT, "R9 light entry");
      wic = 1;            cyc(LIT, "R9 wic ignored in light"); wic = 0;
      irq = 1;            cyc(RUN, "R9 irq wake"); irq = 0;
      deep = 1; wfi = 1;  cyc(DEP, "R9 deep entry");
      wic = 1;            cyc(WPW, "R9 wic wakes deep"); wic = 0;
      for (int i = 1; i < GAP; i++) cyc(WPW, "R10 power stage hold");
      for (int i = 0; i < GAP; i++) cyc(WCK, "R10 clock stage");
                          cyc(RUN, "R10 run after wic");
      // priority of wfi over wfe keeps the latch
      deep = 0;
      evt = 1;            cyc(RUN, "R11 latch event");
      wfi = 1; wfe = 1;   cyc(LIT, "R2 wfi wins over wfe");
      irq = 1;            cyc(RUN, "R2 irq wake"); irq = 0;
      wfe = 1;            cyc(RUN, "R2 latch kept after priority");
      // requests ignored during wake stages
      deep = 1; wfi = 1;  cyc(DEP, "R12 deep entry");
      deep = 0; irq = 1;  cyc(WPW, "R12 wake starts"); irq = 0;
      wfi = 1;            cyc(GAP > 1 ? WPW : WCK, "R12 wfi ignored in stage");
      for (int i = 2; i < 2 * GAP; i++) cyc(i < GAP ? WPW : WCK, "R12 stage continues");
                          cyc(RUN, "R12 back to run");
      @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule